// File: doc/BRIEF.md
# Signal-Loss Sleep and Mute Controller

This block decides, once per clock, whether the datapath of a coaxial cable receiver is powered, muted or bypassed. It takes a raw energy-present flag from an analog detector, an 8-bit cable-length code with a rate flag, a comparator flag from an external threshold, and a set of control fields. The control fields come either from package pins or from register fields. It produces an active-high carrier-loss pin, an active-high carrier-present status bit, a power-down request, a mute command, a bypass command, and the serial data bit after muting.

Carrier loss is raised when energy is absent or when the cable is longer than the selected threshold. The threshold is either an external comparator result or a 5-bit digital code in 10 m steps, applied to a length in metres that is derived from the code and the rate. A sleep policy with a cycle-count entry delay and a wake-up settle timer turns the datapath off when no signal is present, or on command. A strict precedence then resolves sleep, mute and bypass. A one-cycle clear input returns the timers to the powered, settled state.

Top module: `sigloss_pwr_ctl`

## Requirements
- R1: While `pwr_down` is 1, `mute_cmd` and `bypass_cmd` are 0. While `mute_cmd` is 1, `bypass_cmd` is 0.
- R2: When `spi_mode` is 1, `reg_mute` and `reg_bypass` are the mute and bypass requests; otherwise `pin_mute` and `pin_bypass` are. `mute_cmd` is also 1 throughout the wake-up settle interval.
- R3: `cd_pin` equals the loss indication registered once, so it changes one clock after the inputs do. `cd_stat` is always its inverse (1 = carrier present). Reset sets `cd_pin` to 1.
- R4: Loss = not `energy_ok` OR over-length. Over-length is the digital threshold test only when `spi_mode` and `reg_thr_dig` are both 1; otherwise it is `ext_over`.
- R5: Length in quarter-metres: with `rate_sd`=0 it is code×5. With `rate_sd`=1 it is max(0, code×5−80) for codes up to 191 and 875+(code−191)×14 above that. Codes 248–255 count as longer than any threshold. A threshold code k (k<31) is exceeded when length > (k+1)×40 quarter-metres. Code 31 never flags.
- R6: The effective sleep mode is `reg_sleep` in SPI mode, and in pin mode it is 01 when `pin_autosleep` is 1 and 00 otherwise. Mode 00 never powers down. Mode 10 raises `pwr_down` on the next clock whatever the input. Modes 01 and 11 act automatically.
- R7: In automatic mode, a loss seen on `cd_pin` starts a delay of `PD_CYC` clocks, after which `pwr_down` rises. A signal that returns during the delay cancels it.
- R8: When sleep ends (signal back in automatic mode, or mode 00), `pwr_down` falls on the next clock. `mute_cmd` then stays 1 for `WAKE_CYC` clocks. A loss during this interval in automatic mode returns to sleep at once.
- R9: `sdo_bit` is constant 1 whenever `mute_cmd` or `pwr_down` is 1, and equals `sdi_bit` otherwise.
- R10: A 1 on `timer_clr` puts the block in the powered, settled state on the next clock (`pwr_down` 0, no settle mute). It overrides the sleep mode for that clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| timer_clr | input | 1 | One-cycle clear of sleep and wake timers |
| energy_ok | input | 1 | Raw energy-present flag |
| ext_over | input | 1 | External threshold comparator: cable too long |
| len_code | input | 8 | Cable-length code |
| rate_sd | input | 1 | 1 = SD rate, 0 = HD/3G rate |
| sdi_bit | input | 1 | Serial data before muting |
| spi_mode | input | 1 | 1 = register fields control, 0 = pins control |
| pin_mute | input | 1 | Mute pin |
| pin_bypass | input | 1 | Bypass pin |
| pin_autosleep | input | 1 | Auto-sleep pin |
| reg_sleep | input | 2 | Sleep mode field (00 on, 01 auto, 10 forced off, 11 auto) |
| reg_mute | input | 1 | Mute register bit |
| reg_bypass | input | 1 | Bypass register bit |
| reg_thr_dig | input | 1 | 1 = digital threshold, 0 = external |
| reg_thr_code | input | 5 | Digital threshold code |
| cd_pin | output | 1 | Carrier loss, 1 = no valid signal |
| cd_stat | output | 1 | Carrier status, 1 = carrier present |
| pwr_down | output | 1 | Power-down request |
| mute_cmd | output | 1 | Mute command |
| bypass_cmd | output | 1 | Bypass command |
| sdo_bit | output | 1 | Serial data after muting |

## Verification
The properties assume that the control fields are stable register or pin values driven synchronously to `clk`, and that `timer_clr` is a short pulse rather than a level. The forced-sleep and never-sleep properties read the sleep policy straight from the ports, so they take for granted that no clear pulse coincides with them. The bench changes every input shortly after a rising edge, holds the fields for whole stretches of clocks and pulses `timer_clr` for a single clock. It also shortens both timers through parameters, so that delay entry, cancellation and wake-up each occur several times within a short run.

// File: rtl/sigloss_pwr_ctl.sv
module sigloss_pwr_ctl #(
  parameter int PD_CYC   = 9000,
  parameter int WAKE_CYC = 250000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       timer_clr,
  input  logic       energy_ok,
  input  logic       ext_over,
  input  logic [7:0] len_code,
  input  logic       rate_sd,
  input  logic       sdi_bit,
  input  logic       spi_mode,
  input  logic       pin_mute,
  input  logic       pin_bypass,
  input  logic       pin_autosleep,
  input  logic [1:0] reg_sleep,
  input  logic       reg_mute,
  input  logic       reg_bypass,
  input  logic       reg_thr_dig,
  input  logic [4:0] reg_thr_code,
  output logic       cd_pin,
  output logic       cd_stat,
  output logic       pwr_down,
  output logic       mute_cmd,
  output logic       bypass_cmd,
  output logic       sdo_bit
);
  localparam int MAXC  = (PD_CYC > WAKE_CYC) ? PD_CYC : WAKE_CYC;
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam logic [CNT_W-1:0] PD_LAST = CNT_W'(PD_CYC - 1);
  localparam logic [CNT_W-1:0] WK_LAST = CNT_W'(WAKE_CYC - 1);

  typedef enum logic [1:0] {S_ON, S_PEND, S_OFF, S_WAKE} pstate_t;

  pstate_t          st, st_n;
  logic [CNT_W-1:0] cnt, cnt_n;
  logic             loss_q;

  // cable length in quarter-metres
  logic [10:0] len_qm;
  always_comb begin
    if (!rate_sd)
      len_qm = 11'(len_code) * 11'd5;
    else if (len_code < 8'd17)
      len_qm = 11'd0;
    else if (len_code < 8'd192)
      len_qm = 11'(len_code) * 11'd5 - 11'd80;
    else
      len_qm = 11'd875 + 11'(len_code - 8'd191) * 11'd14;
  end

  logic [10:0] thr_qm;
  logic        len_rsvd, dig_over, use_dig, over_len, loss_now;

  assign thr_qm   = (11'(reg_thr_code) + 11'd1) * 11'd40;
  assign len_rsvd = (len_code >= 8'd248);
  assign dig_over = (reg_thr_code != 5'd31) && (len_rsvd || (len_qm > thr_qm));
  assign use_dig  = spi_mode && reg_thr_dig;
  assign over_len = use_dig ? dig_over : ext_over;
  assign loss_now = !energy_ok || over_len;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) loss_q <= 1'b1;
    else        loss_q <= loss_now;

  assign cd_pin  = loss_q;
  assign cd_stat = !loss_q;

  logic [1:0] eff_mode;
  logic       auto_en, forced;

  assign eff_mode = spi_mode ? reg_sleep : {1'b0, pin_autosleep};
  assign auto_en  = eff_mode[0];
  assign forced   = (eff_mode == 2'b10);

  always_comb begin
    st_n  = st;
    cnt_n = cnt;
    if (timer_clr) begin
      st_n  = S_ON;
      cnt_n = '0;
    end else if (forced) begin
      st_n  = S_OFF;
      cnt_n = '0;
    end else begin
      unique case (st)
        S_ON:
          if (auto_en && loss_q) begin
            st_n  = S_PEND;
            cnt_n = '0;
          end
        S_PEND:
          if (!auto_en || !loss_q) begin
            st_n  = S_ON;
            cnt_n = '0;
          end else if (cnt == PD_LAST) begin
            st_n  = S_OFF;
            cnt_n = '0;
          end else begin
            cnt_n = cnt + 1'b1;
          end
        S_OFF:
          if (!auto_en || !loss_q) begin
            st_n  = S_WAKE;
            cnt_n = '0;
          end
        S_WAKE:
          if (auto_en && loss_q) begin
            st_n  = S_OFF;
            cnt_n = '0;
          end else if (cnt == WK_LAST) begin
            st_n  = S_ON;
            cnt_n = '0;
          end else begin
            cnt_n = cnt + 1'b1;
          end
        default: begin
          st_n  = S_ON;
          cnt_n = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st  <= S_ON;
      cnt <= '0;
    end else begin
      st  <= st_n;
      cnt <= cnt_n;
    end

  logic mute_req, byp_req;
  assign mute_req = spi_mode ? reg_mute : pin_mute;
  assign byp_req  = spi_mode ? reg_bypass : pin_bypass;

  assign pwr_down   = (st == S_OFF);
  assign mute_cmd   = !pwr_down && (mute_req || st == S_WAKE);
  assign bypass_cmd = !pwr_down && !mute_cmd && byp_req;
  assign sdo_bit    = (pwr_down || mute_cmd) ? 1'b1 : sdi_bit;
endmodule

module sigloss_pwr_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       timer_clr,
  input logic       energy_ok,
  input logic       spi_mode,
  input logic       pin_mute,
  input logic       pin_autosleep,
  input logic [1:0] reg_sleep,
  input logic       reg_mute,
  input logic       cd_pin,
  input logic       cd_stat,
  input logic       pwr_down,
  input logic       mute_cmd,
  input logic       bypass_cmd,
  input logic       sdo_bit
);
  logic forced_in, never_in, mute_in;
  assign forced_in = spi_mode && (reg_sleep == 2'b10);
  assign never_in  = spi_mode ? (reg_sleep == 2'b00) : !pin_autosleep;
  assign mute_in   = spi_mode ? reg_mute : pin_mute;

  p_sleep_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |-> (!mute_cmd && !bypass_cmd));
  p_mute_over_bypass_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mute_cmd |-> !bypass_cmd);
  p_cd_sense_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cd_pin != cd_stat);
  p_energy_loss_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !energy_ok |=> cd_pin);
  p_forced_sleep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (forced_in && !timer_clr) |=> pwr_down);
  p_never_sleep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (never_in && !pwr_down) |=> !pwr_down);
  p_mute_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mute_in |-> sdo_bit);
  p_clr_wakes_r10: assert property (@(posedge clk) disable iff (!rst_n)
    timer_clr |=> (!pwr_down && (mute_cmd == mute_in)));
endmodule

bind sigloss_pwr_ctl sigloss_pwr_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .timer_clr(timer_clr), .energy_ok(energy_ok),
  .spi_mode(spi_mode), .pin_mute(pin_mute), .pin_autosleep(pin_autosleep),
  .reg_sleep(reg_sleep), .reg_mute(reg_mute), .cd_pin(cd_pin), .cd_stat(cd_stat),
  .pwr_down(pwr_down), .mute_cmd(mute_cmd), .bypass_cmd(bypass_cmd), .sdo_bit(sdo_bit)
);

// File: tb/tb_sigloss_pwr_ctl.sv
`timescale 1ns/1ps
module tb_sigloss_pwr_ctl;
  localparam int PD  = 6;
  localparam int WK  = 10;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, timer_clr, energy_ok, ext_over, rate_sd, sdi_bit, spi_mode;
  logic pin_mute, pin_bypass, pin_autosleep, reg_mute, reg_bypass, reg_thr_dig;
  logic [7:0] len_code;
  logic [1:0] reg_sleep;
  logic [4:0] reg_thr_code;
  logic cd_pin, cd_stat, pwr_down, mute_cmd, bypass_cmd, sdo_bit;

  sigloss_pwr_ctl #(.PD_CYC(PD), .WAKE_CYC(WK)) dut (.*);

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    sdi_bit <= cyc[0] ^ cyc[3];
  end

  // reference model: 0 on, 1 pending, 2 off, 3 waking
  int m_st, m_cnt;
  bit m_loss;

  function automatic int qmetres(int c, bit sd);
    int v;
    if (!sd) return c * 5;
    if (c <= 191) begin
      v = c * 5 - 80;
      return (v < 0) ? 0 : v;
    end
    return 875 + (c - 191) * 14;
  endfunction

  function automatic bit model_loss();
    bit over;
    if (spi_mode && reg_thr_dig) begin
      if (reg_thr_code == 31) over = 0;
      else if (len_code >= 248) over = 1;
      else over = qmetres(len_code, rate_sd) > (reg_thr_code + 1) * 40;
    end else over = ext_over;
    return !energy_ok || over;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_loss = 1;
    end else begin
      int mode;
      bit aut, frc;
      mode = spi_mode ? reg_sleep : (pin_autosleep ? 1 : 0);
      aut = (mode == 1 || mode == 3);
      frc = (mode == 2);
      if (timer_clr) begin m_st = 0; m_cnt = 0; end
      else if (frc) begin m_st = 2; m_cnt = 0; end
      else if (m_st == 0) begin
        if (aut && m_loss) begin m_st = 1; m_cnt = 0; end
      end else if (m_st == 1) begin
        if (!aut || !m_loss) begin m_st = 0; m_cnt = 0; end
        else if (m_cnt == PD - 1) begin m_st = 2; m_cnt = 0; end
        else m_cnt++;
      end else if (m_st == 2) begin
        if (!aut || !m_loss) begin m_st = 3; m_cnt = 0; end
      end else begin
        if (aut && m_loss) begin m_st = 2; m_cnt = 0; end
        else if (m_cnt == WK - 1) begin m_st = 0; m_cnt = 0; end
        else m_cnt++;
      end
      m_loss = model_loss();
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    bit e_pd, e_mu, e_by, mreq, breq;
    mreq = spi_mode ? reg_mute : pin_mute;
    breq = spi_mode ? reg_bypass : pin_bypass;
    e_pd = (m_st == 2);
    e_mu = !e_pd && (mreq || m_st == 3);
    e_by = !e_pd && !e_mu && breq;
    chk("R3 cd_pin", cd_pin, m_loss);
    chk("R3 cd_stat", cd_stat, !m_loss);
    chk("R6/R7/R8 pwr_down", pwr_down, e_pd);
    chk("R2/R8 mute_cmd", mute_cmd, e_mu);
    chk("R1 bypass_cmd", bypass_cmd, e_by);
    chk("R9 sdo_bit", sdo_bit, (e_pd || e_mu) ? 1 : sdi_bit);
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic see();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 0; timer_clr = 0; energy_ok = 1; ext_over = 0; rate_sd = 0; sdi_bit = 0;
    spi_mode = 0; pin_mute = 0; pin_bypass = 0; pin_autosleep = 0;
    reg_sleep = 2'b01; reg_mute = 0; reg_bypass = 0; reg_thr_dig = 0;
    reg_thr_code = 5'd31; len_code = 8'd0;
    @(posedge clk); @(negedge clk);
    chk("R3 reset cd_pin", cd_pin, 1);
    chk("R6 reset pwr_down", pwr_down, 0);
    step(1); rst_n = 1;
    step(3);

    // pin mode, sleep 00
    pin_bypass = 1; see();
    chk("R2 pin bypass", bypass_cmd, 1);
    step(0); pin_mute = 1; see();
    chk("R1 mute wins over bypass", bypass_cmd, 0);
    chk("R9 muted output high", sdo_bit, 1);
    step(0); pin_mute = 0; pin_bypass = 0; energy_ok = 0;
    step(1); @(negedge clk);
    chk("R4 energy loss raises cd", cd_pin, 1);
    step(20); @(negedge clk);
    chk("R6 mode 00 never sleeps", pwr_down, 0);
    step(0); ext_over = 1; energy_ok = 1; see();
    chk("R4 external threshold in pin mode", cd_pin, 1);
    step(0); ext_over = 0; step(3);

    // pin autosleep: cancel, then sleep
    pin_autosleep = 1; energy_ok = 0;
    step(3); energy_ok = 1;
    step(12); @(negedge clk);
    chk("R7 returned signal cancels delay", pwr_down, 0);
    step(0); energy_ok = 0; pin_mute = 1;
    step(PD + 3); @(negedge clk);
    chk("R7 sleep after delay", pwr_down, 1);
    chk("R1 sleep clears mute", mute_cmd, 0);
    step(0); pin_mute = 0; energy_ok = 1;
    step(3); @(negedge clk);
    chk("R8 settle mute held", mute_cmd, 1);
    step(WK); @(negedge clk);
    chk("R8 settle done", mute_cmd, 0);
    step(0); energy_ok = 0;
    step(PD + 3); energy_ok = 1;
    step(3); energy_ok = 0;
    step(4); @(negedge clk);
    chk("R8 loss while settling sleeps", pwr_down, 1);
    step(0); timer_clr = 1; step(1); timer_clr = 0; @(negedge clk);
    chk("R10 clear wakes", pwr_down, 0);
    chk("R10 clear skips settle", mute_cmd, 0);
    step(PD + 4); energy_ok = 1; step(WK + 4);

    // SPI mode sleep policy
    spi_mode = 1; reg_sleep = 2'b10; see();
    chk("R6 forced sleep", pwr_down, 1);
    step(0); reg_sleep = 2'b11; energy_ok = 1; step(WK + 3);
    energy_ok = 0; step(PD + 3); @(negedge clk);
    chk("R6 mode 11 acts as auto", pwr_down, 1);
    step(0); reg_sleep = 2'b00; step(WK + 3); energy_ok = 1;
    reg_mute = 1; pin_mute = 0; see();
    chk("R2 register mute in SPI mode", mute_cmd, 1);
    step(0); reg_mute = 0; reg_bypass = 1; pin_bypass = 0; see();
    chk("R2 register bypass in SPI mode", bypass_cmd, 1);
    step(0); reg_bypass = 0;

    // digital threshold tests (R5)
    reg_thr_dig = 1; ext_over = 1; reg_thr_code = 5'd0; rate_sd = 0;
    len_code = 8'd8; step(1); see();
    chk("R5 HD 10m not over code 0", cd_pin, 0);
    step(0); len_code = 8'd9; see();
    chk("R5 HD 11.25m over code 0", cd_pin, 1);
    step(0); rate_sd = 1; len_code = 8'd24; see();
    chk("R5 SD 10m not over code 0", cd_pin, 0);
    step(0); len_code = 8'd25; see();
    chk("R5 SD 11.25m over code 0", cd_pin, 1);
    step(0); len_code = 8'd10; see();
    chk("R5 SD short code clamps to 0", cd_pin, 0);
    step(0); len_code = 8'd200; reg_thr_code = 5'd24; see();
    chk("R5 SD upper segment over 250m", cd_pin, 1);
    step(0); reg_thr_code = 5'd25; see();
    chk("R5 SD upper segment under 260m", cd_pin, 0);
    step(0); len_code = 8'd250; reg_thr_code = 5'd30; see();
    chk("R5 reserved code exceeds", cd_pin, 1);
    step(0); len_code = 8'd255; reg_thr_code = 5'd31; see();
    chk("R5 code 31 never flags", cd_pin, 0);
    step(0); spi_mode = 0; reg_thr_code = 5'd0; ext_over = 0; see();
    chk("R4 digital select ignored in pin mode", cd_pin, 0);
    step(5);
    finish_run();
  end
endmodule